// File: doc/BRIEF.md
# Hash Wrapper Block-Assembly Controller

This block sits between a 32-bit host bus, an upstream padder and a hash core. It takes already padded 32-bit words one per accepted transfer and shifts them into a block register. When the block is full, it raises a one-cycle load strobe to the core. The first word of a block lands in the most significant bits. With a non-zero counter width, a running block index travels beside the message bits, in the low bits of the core bus. A salt value is sampled once per block and held toward the core.

If the host marks a word as the last of the message before the block is full, the controller fills the remaining word slots with zeros itself, one slot per cycle. After a non-final block it accepts no new words until the core reports ready. After the final block it waits for the core's done pulse and captures the digest. It then returns the digest as consecutive 32-bit words, most significant first, truncated to the selected output length.

Top module: `hwrap_ctrl`

## Requirements
- R1: After a synchronous reset `in_ready` is 1, `core_load`, `core_final` and `out_valid` are 0, and `core_block` is all zeros.
- R2: A word is taken when `in_valid` and `in_ready` are both 1 at a clock edge. Words shift in from the right, so the first word of a block ends in bits [CTR_W+BLOCK_W-1 -: 32]. `core_load` is high for exactly one cycle, starting the cycle after the edge that completed the block.
- R3: The low CTR_W bits of `core_block` carry the block index during load. The index is 1 for the first block of a message and rises by one per block. It restarts at 1 for the next message after the digest has been returned.
- R4: When the accepted word carrying `in_last` leaves the block short, the remaining slots are filled with zero words, one per cycle. `in_ready` is 0 during the fill. `core_load` rises after the last slot is filled.
- R5: `core_final` is 1 together with `core_load` exactly for the block that contains the `in_last` word. It is never 1 without `core_load`.
- R6: After a non-final load, `in_ready` stays 0 until `core_ready` is seen high at a clock edge. It is 1 in the cycle after that edge.
- R7: After the final load, no words are taken and no output is produced until `core_done` is seen. `core_digest` is captured on that edge.
- R8: After the capture edge, `out_valid` is 1 for OUT_W/32 consecutive cycles. `out_data` gives the top OUT_W bits of the digest, most significant word first; the low DIG_W-OUT_W bits are dropped. `in_ready` returns to 1 in the following cycle.
- R9: `core_salt` holds the `salt_in` value sampled on the edge that completed the block. Changes to `salt_in` after that edge do not reach `core_salt` before the next block completes.
- R10: A synchronous reset in the middle of a block discards the partial words and the block index. The next block starts at slot 0 with index 1.
- R11: `in_valid` has no effect while `in_ready` is 0. Words driven then do not appear in any block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host word valid |
| in_data | input | 32 | Padded host word |
| in_last | input | 1 | Marks the last padded word of the message |
| in_ready | output | 1 | Controller is taking words |
| salt_in | input | SALT_W (min 1) | Salt to pass with each block |
| core_block | output | BLOCK_W+CTR_W | Assembled block, block index in low bits |
| core_salt | output | SALT_W (min 1) | Salt held for the current block |
| core_load | output | 1 | One-cycle block load strobe |
| core_final | output | 1 | Current loaded block is the last of the message |
| core_ready | input | 1 | Core can take the next block |
| core_done | input | 1 | Core digest is valid |
| core_digest | input | DIG_W | Digest from the core |
| out_valid | output | 1 | Digest word valid |
| out_data | output | 32 | Digest word, most significant first |

## Verification
A word is accepted at an edge. The load strobe, block contents, index, salt and final flag are due the cycle after the edge that fills the last slot. A short block is due N-k edges after its k-th word. The bench drives at the falling edge and compares at the falling edge exactly that many edges later. Digest words appear one per cycle, starting one edge after `core_done` is taken. The return of `in_ready` is checked one edge after `core_ready` or after the last digest word. Ignored stimulus during the busy states is checked through the contents of the next loaded block.

// File: rtl/hwrap_pkg.sv
package hwrap_pkg;
    localparam int unsigned BUS_W = 32;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PAD,
        ST_LOAD,
        ST_NEXT,
        ST_WAIT,
        ST_OUT
    } hw_state_e;

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/hwrap_collect.sv
module hwrap_collect
    import hwrap_pkg::*;
#(
    parameter int unsigned BLOCK_W = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               zero_fill,
    input  logic [BUS_W-1:0]   din,
    output logic [BLOCK_W-1:0] block,
    output logic               last_slot
);
    localparam int unsigned WPB = BLOCK_W / BUS_W;
    localparam int unsigned CW  = cnt_bits(WPB);

    logic [CW-1:0]    wcnt;
    logic [BUS_W-1:0] word_in;

    assign word_in   = zero_fill ? '0 : din;
    assign last_slot = (wcnt == CW'(WPB - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (shift_en) begin
            wcnt <= last_slot ? '0 : wcnt + 1'b1;
        end
    end

    generate
        if (WPB > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) block <= '0;
                else if (shift_en) block <= {block[BLOCK_W-BUS_W-1:0], word_in};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) block <= '0;
                else if (shift_en) block <= word_in;
            end
        end
    endgenerate

    // R4
    wrap_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && last_slot) |=> (wcnt == '0));
endmodule

// File: rtl/hwrap_blkctr.sv
module hwrap_blkctr #(
    parameter int unsigned CTR_W = 64
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                clr,
    input  logic                                inc,
    output logic [(CTR_W > 0 ? CTR_W : 1)-1:0] cnt
);
    generate
        if (CTR_W > 0) begin : g_ctr
            always_ff @(posedge clk) begin
                if (rst || clr) cnt <= '0;
                else if (inc) cnt <= cnt + 1'b1;
            end

            // R3
            ctr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
                (inc && !clr && (cnt != '1)) |=> (cnt != '0));
        end else begin : g_none
            assign cnt = '0;
        end
    endgenerate
endmodule

// File: rtl/hwrap_emit.sv
module hwrap_emit
    import hwrap_pkg::*;
#(
    parameter int unsigned DIG_W = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             advance,
    input  logic [DIG_W-1:0] digest_in,
    output logic [BUS_W-1:0] word_out
);
    logic [DIG_W-1:0] dreg;

    assign word_out = dreg[DIG_W-1 -: BUS_W];

    generate
        if (DIG_W > BUS_W) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst) dreg <= '0;
                else if (capture) dreg <= digest_in;
                else if (advance) dreg <= {dreg[DIG_W-BUS_W-1:0], {BUS_W{1'b0}}};
            end
        end else begin : g_narrow
            always_ff @(posedge clk) begin
                if (rst) dreg <= '0;
                else if (capture) dreg <= digest_in;
            end
        end
    endgenerate
endmodule

// File: rtl/hwrap_ctrl.sv
module hwrap_ctrl
    import hwrap_pkg::*;
#(
    parameter int unsigned BLOCK_W = 256,
    parameter int unsigned CTR_W   = 64,
    parameter int unsigned SALT_W  = 128,
    parameter int unsigned DIG_W   = 256,
    parameter int unsigned OUT_W   = 224
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    input  logic [31:0]                           in_data,
    input  logic                                  in_last,
    output logic                                  in_ready,
    input  logic [(SALT_W > 0 ? SALT_W : 1)-1:0]  salt_in,
    output logic [BLOCK_W+CTR_W-1:0]              core_block,
    output logic [(SALT_W > 0 ? SALT_W : 1)-1:0]  core_salt,
    output logic                                  core_load,
    output logic                                  core_final,
    input  logic                                  core_ready,
    input  logic                                  core_done,
    input  logic [DIG_W-1:0]                      core_digest,
    output logic                                  out_valid,
    output logic [31:0]                           out_data
);
    localparam int unsigned OW  = OUT_W / BUS_W;
    localparam int unsigned OCW = cnt_bits(OW);
    localparam int unsigned CTW = (CTR_W > 0) ? CTR_W : 1;

    hw_state_e        state, state_nx;
    logic             last_q;
    logic [OCW-1:0]   ocnt;
    logic             accept, shift_en, last_slot, blk_done, out_end;
    logic [BLOCK_W-1:0] msg_block;
    logic [CTW-1:0]   ctr;

    assign accept   = in_valid && (state == ST_READ);
    assign shift_en = accept || (state == ST_PAD);
    assign blk_done = shift_en && last_slot;
    assign out_end  = (state == ST_OUT) && (ocnt == OCW'(OW - 1));

    hwrap_collect #(.BLOCK_W(BLOCK_W)) u_collect (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .zero_fill (state == ST_PAD),
        .din       (in_data),
        .block     (msg_block),
        .last_slot (last_slot)
    );

    hwrap_blkctr #(.CTR_W(CTR_W)) u_ctr (
        .clk (clk),
        .rst (rst),
        .clr (out_end),
        .inc (blk_done),
        .cnt (ctr)
    );

    hwrap_emit #(.DIG_W(DIG_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .capture   ((state == ST_WAIT) && core_done),
        .advance   (state == ST_OUT),
        .digest_in (core_digest),
        .word_out  (out_data)
    );

    generate
        if (CTR_W > 0) begin : g_aug
            assign core_block = {msg_block, ctr};
        end else begin : g_plain
            assign core_block = msg_block;
        end
    endgenerate

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READ: if (accept) begin
                if (last_slot)    state_nx = ST_LOAD;
                else if (in_last) state_nx = ST_PAD;
            end
            ST_PAD:  if (last_slot) state_nx = ST_LOAD;
            ST_LOAD: state_nx = last_q ? ST_WAIT : ST_NEXT;
            ST_NEXT: if (core_ready) state_nx = ST_READ;
            ST_WAIT: if (core_done) state_nx = ST_OUT;
            ST_OUT:  if (out_end) state_nx = ST_READ;
            default: state_nx = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_READ;
            last_q    <= 1'b0;
            ocnt      <= '0;
            core_salt <= '0;
        end else begin
            state <= state_nx;
            if (accept && in_last) last_q <= 1'b1;
            else if (out_end)      last_q <= 1'b0;
            if (blk_done) core_salt <= salt_in;
            if (state == ST_OUT) ocnt <= out_end ? '0 : ocnt + 1'b1;
        end
    end

    assign in_ready   = (state == ST_READ);
    assign core_load  = (state == ST_LOAD);
    assign core_final = (state == ST_LOAD) && last_q;
    assign out_valid  = (state == ST_OUT);

    // R2
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        core_load |=> !core_load);
    // R5
    final_with_load_chk: assert property (@(posedge clk) disable iff (rst)
        core_final |-> core_load);
    // R6
    hold_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        (core_load && !core_final) |=> !in_ready);
    // R7
    wait_digest_chk: assert property (@(posedge clk) disable iff (rst)
        (core_load && core_final) |=> (!in_ready && !out_valid));
    // R8
    out_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);
endmodule

// File: tb/hwrap_ctrl_test.sv
`timescale 1ns/1ps
module hwrap_ctrl_test;
    localparam int BW = 256, CW = 64, SW = 128, DW = 256, OWID = 224;
    localparam int WPB = BW / 32;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 0, in_last = 0, core_ready = 0, core_done = 0;
    logic [31:0] in_data = '0;
    logic [SW-1:0] salt_in = '0;
    logic [DW-1:0] core_digest = '0;
    logic in_ready, core_load, core_final, out_valid;
    logic [BW+CW-1:0] core_block;
    logic [SW-1:0] core_salt;
    logic [31:0] out_data;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    hwrap_ctrl #(.BLOCK_W(BW), .CTR_W(CW), .SALT_W(SW), .DIG_W(DW), .OUT_W(OWID)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .salt_in(salt_in), .core_block(core_block), .core_salt(core_salt),
        .core_load(core_load), .core_final(core_final), .core_ready(core_ready),
        .core_done(core_done), .core_digest(core_digest), .out_valid(out_valid),
        .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [383:0] act, input logic [383:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w, input bit last);
        int guard = 0;
        while (!in_ready && guard < 50) begin
            @(posedge clk); @(negedge clk); guard++;
        end
        in_valid = 1'b1; in_data = w; in_last = last;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    endtask

    task automatic check_load(input logic [BW-1:0] msg, input logic [CW-1:0] idx,
                              input bit fin, input logic [SW-1:0] salt, input string tag);
        chk(core_load == 1'b1, {tag, " R2 load"}, core_load, 1);
        chk(core_block == {msg, idx}, {tag, " R2/R3 block"}, core_block, {msg, idx});
        chk(core_final == fin, {tag, " R5 final"}, core_final, fin);
        chk(core_salt == salt, {tag, " R9 salt"}, core_salt, salt);
        @(posedge clk); @(negedge clk);
        chk(core_load == 1'b0, {tag, " R2 strobe width"}, core_load, 0);
        chk(in_ready == 1'b0, {tag, " R6/R7 busy"}, in_ready, 0);
    endtask

    task automatic release_core(input string tag);
        core_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        core_ready = 1'b0;
        chk(in_ready == 1'b1, {tag, " R6 ready returns"}, in_ready, 1);
    endtask

    task automatic read_digest(input logic [DW-1:0] d, input string tag);
        repeat (2) begin
            @(posedge clk); @(negedge clk);
            chk(in_ready == 0 && out_valid == 0, {tag, " R7 waiting"}, {in_ready, out_valid}, 0);
        end
        core_done = 1'b1; core_digest = d;
        @(posedge clk); @(negedge clk);
        core_done = 1'b0; core_digest = '0;
        for (int i = 0; i < OWID / 32; i++) begin
            chk(out_valid == 1'b1, {tag, " R8 valid"}, out_valid, 1);
            chk(out_data == d[DW-1-32*i -: 32], {tag, " R8 word"}, out_data, d[DW-1-32*i -: 32]);
            @(posedge clk); @(negedge clk);
        end
        chk(out_valid == 0 && in_ready == 1, {tag, " R8 truncated end"}, {out_valid, in_ready}, 2'b01);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(in_ready == 1 && core_load == 0 && core_final == 0 && out_valid == 0,
            "R1 flags", {in_ready, core_load, core_final, out_valid}, 4'b1000);
        chk(core_block == '0, "R1 block", core_block, 0);
    endtask

    task automatic t_two_blocks();
        logic [BW-1:0] m = '0;
        salt_in = {4{32'hA5A50001}};
        for (int i = 0; i < WPB; i++) begin
            push(32'h1000_0000 + i, 1'b0);
            m = {m[BW-33:0], 32'h1000_0000 + i};
        end
        check_load(m, 64'd1, 1'b0, {4{32'hA5A50001}}, "blkA");
        // R9: salt changes after completion do not reach the core
        salt_in = {4{32'h5A5A0002}};
        // R11: words driven while busy are ignored
        in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            chk(in_ready == 0, "R6 held off", in_ready, 0);
        end
        chk(core_salt == {4{32'hA5A50001}}, "R9 salt held", core_salt, {4{32'hA5A50001}});
        in_valid = 1'b0;
        release_core("blkA");
        m = '0;
        for (int i = 0; i < WPB; i++) begin
            push(32'h2000_0000 + i, i == WPB - 1);
            m = {m[BW-33:0], 32'h2000_0000 + i};
        end
        check_load(m, 64'd2, 1'b1, {4{32'h5A5A0002}}, "blkB R11");
        read_digest({32'h01234567, 32'h89ABCDEF, 32'h0F1E2D3C, 32'h4B5A6978,
                     32'h87969594, 32'hA3B2C1D0, 32'hE1F20314, 32'hFFEEDDCC}, "two");
    endtask

    task automatic t_short_pad();
        logic [BW-1:0] m = '0;
        for (int i = 0; i < 3; i++) begin
            push(32'h3000_0000 + i, i == 2);
            m = {m[BW-33:0], 32'h3000_0000 + i};
        end
        m = m << (32 * (WPB - 3));
        for (int i = 0; i < WPB - 3; i++) begin
            chk(in_ready == 0 && core_load == 0, "R4 filling", {in_ready, core_load}, 0);
            @(posedge clk); @(negedge clk);
        end
        check_load(m, 64'd1, 1'b1, salt_in, "pad R3 restart R4");
        read_digest({8{32'hC0DE_0001}} ^ {DW{1'b1}}, "pad");
    endtask

    task automatic t_mid_reset();
        logic [BW-1:0] m = '0;
        for (int i = 0; i < WPB; i++) begin
            push(32'h4000_0000 + i, 1'b0);
            m = {m[BW-33:0], 32'h4000_0000 + i};
        end
        check_load(m, 64'd1, 1'b0, salt_in, "pre");
        release_core("pre");
        for (int i = 0; i < 3; i++) push(32'h5000_0000 + i, 1'b0);
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        chk(core_block == '0 && in_ready == 1, "R10 cleared", core_block, 0);
        m = '0;
        for (int i = 0; i < 2; i++) begin
            push(32'h6000_0000 + i, i == 1);
            m = {m[BW-33:0], 32'h6000_0000 + i};
        end
        m = m << (32 * (WPB - 2));
        repeat (WPB - 2) begin @(posedge clk); @(negedge clk); end
        check_load(m, 64'd1, 1'b1, salt_in, "R10 post");
        read_digest({8{32'h7777_1111}}, "post");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_two_blocks();
        t_short_pad();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule